// File: doc/BRIEF.md
# Microcontroller Three-Port I/O Unit

This block gives a small accumulator-based microcontroller three 8-bit general-purpose ports. Each port has an 8-bit input bus, an 8-bit data output latch, an 8-bit direction/control output and a one-cycle output strobe. An external FIFO can capture the data output on that strobe. A port can work as separate input and output lines, or as one bidirectional bus when the control output drives external tristate buffers.

The CPU reaches the data latches through a simple register bus with address, write data, write enable and read data. The control registers have no bus address. They are loaded only through a dedicated path that copies the accumulator into the port chosen by a 2-bit select. All state changes on the rising edge of the single clock. Reset is synchronous and active high.

Top module: `mcu_port_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every port's control output becomes 0xFF (all pins inputs), every data output becomes 0x00 and all strobes become 0.
- R2: A bus write (`bus_we`=1) to address 0x05, 0x06 or 0x07 loads `bus_wdata` into the data output of port 0, 1 or 2 respectively at that clock edge; port n occupies bits [8n+7:8n] of every packed port bus.
- R3: A port's strobe is high for exactly the one cycle after a bus write to that port's address, which is the same cycle in which the new data value first appears. A write to any other address raises no strobe.
- R4: A read returns, for addresses 0x05 to 0x07, the port's input bus as it was sampled at the most recent clock edge (one register stage, never the output latch); for every other address the read data is 0x00.
- R5: When `ctl_load` is 1 and `ctl_sel` is 0, 1 or 2, the accumulator value `acc` is loaded into that port's control output at the clock edge.
- R6: When `ctl_load` is 1 with `ctl_sel` equal to 3, no control output changes.
- R7: Bus writes, to any address, never change any control output.
- R8: A data output keeps its value in every cycle without a bus write to its address, whatever `ctl_load`, `ctl_sel` and the bus address do when `bus_we` is 0.

Port mapping: port n is at address 0x05+n and at bits [8n+7:8n] of `pin_in`, `dat_out` and `ctl_out`, and at bit n of `stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register bus write enable |
| bus_rdata | output | 8 | Register bus read data |
| ctl_load | input | 1 | Load the accumulator into a control register |
| ctl_sel | input | 2 | Port chosen by the control load (3 = none) |
| acc | input | 8 | Accumulator value |
| pin_in | input | 24 | Input buses of the three ports, packed |
| dat_out | output | 24 | Data output latches, packed |
| ctl_out | output | 24 | Control/direction outputs, packed |
| stb | output | 3 | One-cycle output strobes, one per port |

## Verification
The hardest case to create is two writes to the same port on consecutive cycles. The strobe must then stay high for two cycles while the data changes under it. In the same case a control load, or a select of 3, may arrive together with a bus write. The stimulus draws addresses weighted toward 0x05 to 0x07, together with random write enables, control loads and all four select values. This makes back-to-back writes and overlaps of the two paths frequent. Directed steps add a write with enable low, writes to 0x04 and 0x08, and a pin change in the same cycle as a read of that port.

// File: rtl/mcu_port_unit.sv
module mcu_port_unit #(
  parameter int PORTS = 3,
  parameter int W     = 8,
  parameter int AW    = 5,
  parameter int BASE  = 5,
  parameter int SW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic [W-1:0]       bus_wdata,
  input  logic               bus_we,
  output logic [W-1:0]       bus_rdata,
  input  logic               ctl_load,
  input  logic [SW-1:0]      ctl_sel,
  input  logic [W-1:0]       acc,
  input  logic [PORTS*W-1:0] pin_in,
  output logic [PORTS*W-1:0] dat_out,
  output logic [PORTS*W-1:0] ctl_out,
  output logic [PORTS-1:0]   stb
);
  localparam int BUSW = PORTS * W;

  logic [BUSW-1:0]  in_q;
  logic [PORTS-1:0] hit;

  always_ff @(posedge clk) in_q <= pin_in;

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    assign hit[i] = (bus_addr == AW'(BASE + i));

    always_ff @(posedge clk) begin
      if (rst) begin
        dat_out[i*W +: W] <= '0;
        ctl_out[i*W +: W] <= '1;
        stb[i]            <= 1'b0;
      end else begin
        stb[i] <= bus_we && hit[i];
        if (bus_we && hit[i]) dat_out[i*W +: W] <= bus_wdata;
        if (ctl_load && ctl_sel == SW'(i)) ctl_out[i*W +: W] <= acc;
      end
    end

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == AW'(BASE + i)) |=>
        (dat_out[i*W +: W] == $past(bus_wdata)));
    assert_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == AW'(BASE + i)) |=> stb[i]);
    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      !(bus_we && bus_addr == AW'(BASE + i)) |=> !stb[i]);
    assert_read_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == AW'(BASE + i)) |-> (bus_rdata == $past(pin_in[i*W +: W])));
    assert_ctl_load_R5: assert property (@(posedge clk) disable iff (rst)
      (ctl_load && ctl_sel == SW'(i)) |=> (ctl_out[i*W +: W] == $past(acc)));
    assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !(ctl_load && ctl_sel == SW'(i)) |=> $stable(ctl_out[i*W +: W]));
    assert_dat_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(bus_we && bus_addr == AW'(BASE + i)) |=> $stable(dat_out[i*W +: W]));
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < PORTS; i++)
      if (hit[i]) bus_rdata = in_q[i*W +: W];
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ctl_out == '1 && dat_out == '0 && stb == '0));
  assert_sel_none_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_load && int'(ctl_sel) >= PORTS) |=> $stable(ctl_out));
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
endmodule

// File: tb/mcu_port_unit_bench.sv
`timescale 1ns/100ps
module mcu_port_unit_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_rdata;
  logic        ctl_load = 0;
  logic [1:0]  ctl_sel = 0;
  logic [7:0]  acc = 0;
  logic [23:0] pin_in = 0;
  logic [23:0] dat_out, ctl_out;
  logic [2:0]  stb;

  int n_run = 0, n_fail = 0;
  logic [7:0]  m_dat [3];
  logic [7:0]  m_ctl [3];
  logic [2:0]  m_stb;
  logic [23:0] pin_seen;
  string lab_dat [3];
  string lab_ctl [3];

  always #2.5 clk = ~clk;

  mcu_port_unit u_mcu_port_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ctl_load(ctl_load),
    .ctl_sel(ctl_sel), .acc(acc), .pin_in(pin_in), .dat_out(dat_out),
    .ctl_out(ctl_out), .stb(stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int port_of(input logic [4:0] a);
    return (a >= 5 && a <= 7) ? int'(a) - 5 : 3;
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a, input logic [23:0] seen);
    int k = port_of(a);
    return (k < 3) ? seen[8*k +: 8] : 8'h00;
  endfunction

  task automatic cyc(input logic we, input logic [4:0] a, input logic [7:0] wd,
                     input logic ld, input logic [1:0] s, input logic [7:0] ac,
                     input logic [23:0] p);
    int k;
    for (int i = 0; i < 3; i++) begin
      check(lab_dat[i], dat_out[8*i +: 8], m_dat[i]);
      check(lab_ctl[i], ctl_out[8*i +: 8], m_ctl[i]);
      check("R3 strobe", stb[i], m_stb[i]);
    end
    bus_we = we; bus_addr = a; bus_wdata = wd;
    ctl_load = ld; ctl_sel = s; acc = ac; pin_in = p;
    #1;
    check("R4 read", bus_rdata, exp_read(a, pin_seen));
    k = port_of(a);
    m_stb = 0;
    for (int i = 0; i < 3; i++) begin
      lab_dat[i] = "R8 data hold";
      lab_ctl[i] = (we && k < 3) ? "R7 ctl vs bus write" : "R5 ctl hold";
      if (ld && s == 2'd3) lab_ctl[i] = "R6 sel 3 ignored";
    end
    if (we && k < 3) begin
      m_dat[k] = wd; m_stb[k] = 1'b1; lab_dat[k] = "R2 data write";
    end
    if (ld && s != 2'd3) begin
      m_ctl[s] = ac; lab_ctl[s] = "R5 ctl load";
    end
    @(posedge clk);
    pin_seen = p;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired (R1..R8 incomplete)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1657));
    for (int i = 0; i < 3; i++) begin
      m_dat[i] = 8'h00; m_ctl[i] = 8'hFF;
      lab_dat[i] = "R8 data hold"; lab_ctl[i] = "R5 ctl hold";
    end
    m_stb = 0;
    pin_in = 24'hA5C33C;
    pin_seen = 24'hA5C33C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset dat", dat_out, 24'h000000);
    check("R1 reset ctl", ctl_out, 24'hFFFFFF);
    check("R1 reset stb", stb, 3'b000);
    rst = 0;

    // directed corner cases
    cyc(1, 5'd5, 8'h11, 0, 0, 8'h00, 24'h123456);
    cyc(1, 5'd5, 8'h22, 0, 0, 8'h00, 24'h123456);
    cyc(1, 5'd7, 8'h33, 1, 2'd3, 8'h5A, 24'h654321);
    cyc(0, 5'd6, 8'h77, 1, 2'd1, 8'h0F, 24'h654321);
    cyc(1, 5'd4, 8'h99, 0, 0, 8'h00, 24'hFFFFFF);
    cyc(1, 5'd8, 8'h88, 1, 2'd0, 8'hC3, 24'h000000);
    cyc(1, 5'd6, 8'h44, 1, 2'd1, 8'h3C, 24'h00FF00);
    cyc(0, 5'd6, 8'h00, 0, 0, 8'h00, 24'h0AB000);
    cyc(0, 5'd7, 8'h00, 1, 2'd3, 8'hEE, 24'h0AB000);
    cyc(0, 5'd0, 8'h00, 0, 0, 8'h00, 24'h0AB000);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a;
      a = ($urandom % 2) ? 5'(5 + $urandom % 3) : 5'($urandom);
      cyc(1'($urandom), a, 8'($urandom), 1'($urandom % 3 == 0),
          2'($urandom), 8'($urandom), 24'($urandom));
    end
    cyc(0, 5'd0, 8'h00, 0, 0, 8'h00, 24'h0);

    // reset in mid-run
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 reset dat", dat_out, 24'h000000);
    check("R1 reset ctl", ctl_out, 24'hFFFFFF);
    check("R1 reset stb", stb, 3'b000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule